// File: doc/BRIEF.md
# PCI Master Read Command Sequencer

This block accepts read requests from an upstream memory-mapped port and carries each one out as one or more read transactions on an abstracted PCI bus transaction interface. For every request it is given a start address, a beat count and the address-space type taken from the matching translation entry. It chooses the bus command from the space type, the number of beats still owed and the cacheline size register. It asks the bus side for a transaction and forwards each returned data beat upstream. It then acts on how the bus side ended the transaction.

A normal completion frees the block for the next request. A retry sends the same transaction again. A latency-timer expiry or a target disconnect raises a continuation transaction for the beats still owed. A target-abort or a master-abort is closed upstream with dummy beats that carry an error flag, so the upstream read never stalls. Continuation and the command choice both work from a running address and a remaining-beat counter. Because of this, each re-issued transaction is classified again from where it resumes.

Top module: `pmr_seq_top`

## Requirements
- R1: After reset and whenever no request is in progress, `req_ready` is 1 while `bus_req` and `rsp_valid` are 0. A request is taken on a clock edge where `req_valid` and `req_ready` are both 1, and `req_beats` must be non-zero.
- R2: A request with `req_space` = 01 (I/O) issues command 0010. One with `req_space` = 10 (configuration) issues command 1010. Any other value is memory space.
- R3: A memory-space transaction with exactly one beat outstanding issues command 0110.
- R4: A memory-space transaction with more than one beat that ends inside its cacheline issues command 1110. The cacheline is `cls` DWORDs long, `cls` is a power of two, and the offset is byte address bits [9:2] masked by `cls`-1. Reaching exactly the end of the line does not count as crossing it.
- R5: A memory-space transaction with more than one beat that runs past the end of its cacheline issues command 1100. The same command is used whenever `cls` is 0.
- R6: While `bus_req` is 1 and `bus_ack` is 0, `bus_cmd`, `bus_addr` and `bus_count` keep their values. On the cycle after `bus_ack`, `bus_req` drops.
- R7: Each `bus_rvalid` beat during a transaction appears on `rsp_data` in the same cycle, with `rsp_valid` = 1 and `rsp_err` = 0. Beats beyond the outstanding count are dropped.
- R8: Termination code 000 (count satisfied) ends the request, and the block returns to idle.
- R9: Termination code 011 (retry) re-issues the same command, address and count.
- R10: Termination codes 001 (latency timer) and 010 (target disconnect) re-issue at the address of the first undelivered beat, `DATA_W`/8 bytes per beat. The count is reduced by the beats delivered, and a beat in the same cycle as the termination counts as delivered.
- R11: Termination codes 100 (target-abort) and 101 (master-abort) are followed by one dummy beat per cycle for each undelivered beat. Each dummy beat has all-ones data and `rsp_err` = 1, and the block is then idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Upstream read request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Byte start address |
| req_beats | input | LEN_W | Number of data beats |
| req_space | input | 2 | Space type from the translation entry |
| cls | input | 8 | Cacheline size in DWORDs |
| bus_req | output | 1 | Transaction request to the bus side |
| bus_ack | input | 1 | Bus side accepted the transaction |
| bus_cmd | output | 4 | PCI bus command |
| bus_addr | output | ADDR_W | Transaction start address |
| bus_count | output | LEN_W | Beats in this transaction |
| bus_rvalid | input | 1 | Read data beat from the bus |
| bus_rdata | input | DATA_W | Read data |
| bus_term | input | 1 | Transaction ended this cycle |
| bus_term_code | input | 3 | How it ended |
| rsp_valid | output | 1 | Upstream response beat |
| rsp_data | output | DATA_W | Upstream response data |
| rsp_err | output | 1 | Beat is a dummy from an abort |

## Verification
The interesting overlap is a data beat and a termination arriving in the same cycle. The beat has to be counted before the block decides how much is still owed. The bench drives `bus_rvalid` and `bus_term` together, once with a latency-timer code, where the leftover is a single beat that must come back as command 0110, and once with a target-abort. It judges the result by the address and count of the re-issued transaction, and by the exact number of dummy beats that the scoreboard expects before idle.

// File: rtl/pmr_pkg.sv
package pmr_pkg;
   localparam logic [3:0] CMD_MR  = 4'b0110;
   localparam logic [3:0] CMD_MRL = 4'b1110;
   localparam logic [3:0] CMD_MRM = 4'b1100;
   localparam logic [3:0] CMD_IOR = 4'b0010;
   localparam logic [3:0] CMD_CFR = 4'b1010;

   localparam logic [1:0] SP_IO  = 2'b01;
   localparam logic [1:0] SP_CFG = 2'b10;

   localparam logic [2:0] TC_DONE   = 3'd0;
   localparam logic [2:0] TC_LAT    = 3'd1;
   localparam logic [2:0] TC_DISC   = 3'd2;
   localparam logic [2:0] TC_RETRY  = 3'd3;
   localparam logic [2:0] TC_TABORT = 3'd4;
   localparam logic [2:0] TC_MABORT = 3'd5;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_XFER  = 2'd2,
      ST_DUMMY = 2'd3
   } seq_st_e;
endpackage

// File: rtl/pmr_cmd_sel.sv
module pmr_cmd_sel
   import pmr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic [1:0]        space,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LEN_W-1:0]  beats,
   input  logic [7:0]        cls,
   output logic [3:0]        cmd
);
   localparam int SPAN_W = LEN_W + 10;

   logic [7:0]        off_dw;
   logic [SPAN_W-1:0] len_dw;
   logic [SPAN_W-1:0] span_dw;
   logic              crosses;

   generate
      if (ADDR_W < 10) begin : g_bad_addr
         $error("pmr_cmd_sel: ADDR_W must be at least 10");
      end
      if (DATA_W == 64) begin : g_dw64
         assign len_dw = {9'd0, beats, 1'b0};
      end else begin : g_dw32
         assign len_dw = {10'd0, beats};
      end
   endgenerate

   assign off_dw  = addr[9:2] & (cls - 8'd1);
   assign span_dw = {{(SPAN_W-8){1'b0}}, off_dw} + len_dw;
   assign crosses = (cls == 8'd0) || (span_dw > {{(SPAN_W-8){1'b0}}, cls});

   always_comb begin
      if (space == SP_IO)
         cmd = CMD_IOR;
      else if (space == SP_CFG)
         cmd = CMD_CFR;
      else if (beats == LEN_W'(1))
         cmd = CMD_MR;
      else if (crosses)
         cmd = CMD_MRM;
      else
         cmd = CMD_MRL;
   end
endmodule

// File: rtl/pmr_progress.sv
module pmr_progress #(
   parameter int ADDR_W     = 32,
   parameter int LEN_W      = 8,
   parameter int BEAT_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] ld_addr,
   input  logic [LEN_W-1:0]  ld_beats,
   input  logic              step,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [LEN_W-1:0]  rem,
   output logic [LEN_W-1:0]  rem_after
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         rem      <= '0;
      end else if (load) begin
         cur_addr <= ld_addr;
         rem      <= ld_beats;
      end else if (step) begin
         cur_addr <= cur_addr + ADDR_W'(BEAT_BYTES);
         rem      <= rem - LEN_W'(1);
      end
   end

   assign rem_after = step ? rem - LEN_W'(1) : rem;

   assert_step_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> rem != '0);
   assert_load_excl_R1: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !step);
endmodule

// File: rtl/pmr_seq_top.sv
module pmr_seq_top
   import pmr_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 8,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_beats,
   input  logic [1:0]        req_space,
   input  logic [7:0]        cls,
   output logic              bus_req,
   input  logic              bus_ack,
   output logic [3:0]        bus_cmd,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [LEN_W-1:0]  bus_count,
   input  logic              bus_rvalid,
   input  logic [DATA_W-1:0] bus_rdata,
   input  logic              bus_term,
   input  logic [2:0]        bus_term_code,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_err
);
   localparam int BEAT_BYTES = DATA_W / 8;

   generate
      if (!(DATA_W == 32 || DATA_W == 64)) begin : g_bad_data
         $error("pmr_seq_top: DATA_W must be 32 or 64");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("pmr_seq_top: LEN_W must be positive");
      end
   endgenerate

   seq_st_e          st, st_nx;
   logic [1:0]       space_q;
   logic             load, take, dummy, step;
   logic [LEN_W-1:0] rem, rem_after;

   assign load  = (st == ST_IDLE) && req_valid;
   assign take  = (st == ST_XFER) && bus_rvalid && (rem != '0);
   assign dummy = (st == ST_DUMMY);
   assign step  = take || dummy;

   pmr_progress #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)
   ) u_prog (
      .clk(clk), .rst_n(rst_n), .load(load), .ld_addr(req_addr),
      .ld_beats(req_beats), .step(step), .cur_addr(bus_addr),
      .rem(rem), .rem_after(rem_after)
   );

   pmr_cmd_sel #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)
   ) u_cmd (
      .space(space_q), .addr(bus_addr), .beats(rem), .cls(cls), .cmd(bus_cmd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) space_q <= '0;
      else if (load) space_q <= req_space;
   end

   always_comb begin
      st_nx = st;
      unique case (st)
         ST_IDLE:  if (req_valid) st_nx = ST_ISSUE;
         ST_ISSUE: if (bus_ack) st_nx = ST_XFER;
         ST_XFER: begin
            if (bus_term) begin
               if (bus_term_code == TC_DONE || rem_after == '0)
                  st_nx = ST_IDLE;
               else if (bus_term_code == TC_LAT || bus_term_code == TC_DISC ||
                        bus_term_code == TC_RETRY)
                  st_nx = ST_ISSUE;
               else
                  st_nx = ST_DUMMY;
            end
         end
         ST_DUMMY: if (rem == LEN_W'(1)) st_nx = ST_IDLE;
         default:  st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else st <= st_nx;
   end

   assign req_ready = (st == ST_IDLE);
   assign bus_req   = (st == ST_ISSUE);
   assign bus_count = rem;
   assign rsp_valid = step;
   assign rsp_err   = dummy;
   assign rsp_data  = dummy ? {DATA_W{1'b1}} : bus_rdata;

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_req && !rsp_valid));
   assert_nonzero_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |-> req_beats != '0);
   assert_legal_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> (bus_cmd == CMD_MR || bus_cmd == CMD_MRL || bus_cmd == CMD_MRM ||
                   bus_cmd == CMD_IOR || bus_cmd == CMD_CFR));
   assert_hold_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                 $stable(bus_count) && $stable(bus_cmd)));
   assert_drop_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_ack) |=> !bus_req);
   assert_count_live_R10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req |-> bus_count != '0);
   assert_fwd_beat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_err) |-> bus_rvalid);
   assert_dummy_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (!bus_req && !req_ready && rsp_valid));
endmodule

// File: tb/tb_pmr_seq_top.sv
`timescale 1ns/1ps
module tb_pmr_seq_top;
   localparam int AW = 32, LW = 8, DW = 32;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 0, req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_beats = '0;
   logic [1:0] req_space = '0;
   logic [7:0] cls = 8'd8;
   logic bus_req, bus_ack = 0;
   logic [3:0] bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [LW-1:0] bus_count;
   logic bus_rvalid = 0;
   logic [DW-1:0] bus_rdata = '0;
   logic bus_term = 0;
   logic [2:0] bus_term_code = '0;
   logic rsp_valid, rsp_err;
   logic [DW-1:0] rsp_data;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [DW:0] expq[$];

   always #2 clk = ~clk;

   pmr_seq_top #(.ADDR_W(AW), .LEN_W(LW), .DATA_W(DW)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_beats(req_beats), .req_space(req_space), .cls(cls),
      .bus_req(bus_req), .bus_ack(bus_ack), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .bus_count(bus_count), .bus_rvalid(bus_rvalid), .bus_rdata(bus_rdata),
      .bus_term(bus_term), .bus_term_code(bus_term_code), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .rsp_err(rsp_err));

   task automatic chk(bit ok, string rq, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (expq.size() == 0) begin
            chk(0, "R7", "unexpected response beat", {31'd0, rsp_err, rsp_data}, 64'd0);
         end else begin
            logic [DW:0] e;
            e = expq.pop_front();
            chk({rsp_err, rsp_data} == e, e[DW] ? "R11" : "R7", "response beat",
                {31'd0, rsp_err, rsp_data}, {31'd0, e});
         end
      end
   end

   task automatic send_req(logic [AW-1:0] a, logic [LW-1:0] n, logic [1:0] sp);
      @(posedge clk); #1;
      chk(req_ready == 1'b1, "R1", "ready before request", 64'(req_ready), 64'd1);
      req_valid = 1; req_addr = a; req_beats = n; req_space = sp;
      @(posedge clk); #1;
      req_valid = 0;
   endtask

   task automatic expect_issue(logic [3:0] c, logic [AW-1:0] a, logic [LW-1:0] n,
                               string rq, bit stall);
      @(negedge clk);
      chk(bus_req == 1'b1, rq, "bus_req", 64'(bus_req), 64'd1);
      chk(bus_cmd == c, rq, "bus_cmd", 64'(bus_cmd), 64'(c));
      chk(bus_addr == a, rq, "bus_addr", 64'(bus_addr), 64'(a));
      chk(bus_count == n, rq, "bus_count", 64'(bus_count), 64'(n));
      if (stall) begin
         @(negedge clk);
         chk(bus_req && bus_cmd == c && bus_addr == a && bus_count == n, "R6",
             "hold while unacknowledged", {28'd0, bus_cmd, bus_addr}, {28'd0, c, a});
      end
      @(posedge clk); #1; bus_ack = 1;
      @(posedge clk); #1; bus_ack = 0;
   endtask

   // n data beats; termination either with the last beat or in its own cycle
   task automatic run(int n, logic [DW-1:0] d0, bit with_last, logic [2:0] code);
      for (int i = 0; i < n; i++) begin
         bus_rvalid = 1; bus_rdata = d0 + DW'(i);
         expq.push_back({1'b0, d0 + DW'(i)});
         if (with_last && i == n - 1) begin bus_term = 1; bus_term_code = code; end
         @(posedge clk); #1;
         bus_rvalid = 0; bus_term = 0;
      end
      if (!with_last || n == 0) begin
         bus_term = 1; bus_term_code = code;
         @(posedge clk); #1;
         bus_term = 0;
      end
   endtask

   task automatic push_dummy(int n);
      for (int i = 0; i < n; i++) expq.push_back({1'b1, {DW{1'b1}}});
   endtask

   task automatic wait_idle(string rq);
      int k = 0;
      @(negedge clk);
      while (!req_ready && k < 50) begin @(negedge clk); k++; end
      chk(req_ready == 1'b1, rq, "returned to idle", 64'(req_ready), 64'd1);
      chk(expq.size() == 0, rq, "all expected beats seen", 64'(expq.size()), 64'd0);
   endtask

   initial begin
      #(4 * 100000);
      chk(0, "ALL", "watchdog expired", 64'd0, 64'd1);
      if (!done) begin
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      @(negedge clk);
      chk(req_ready && !bus_req && !rsp_valid, "R1", "reset state",
          {61'd0, req_ready, bus_req, rsp_valid}, 64'd4);

      // R3, R8: single beat memory read
      send_req(32'h100, 1, 2'b00);
      expect_issue(4'b0110, 32'h100, 1, "R3", 0);
      run(1, 32'hA000, 1, 3'd0);
      wait_idle("R8");

      // R4: within line, and exactly reaching the line end
      send_req(32'h100, 4, 2'b00);
      expect_issue(4'b1110, 32'h100, 4, "R4", 1);
      run(4, 32'hB000, 1, 3'd0);
      wait_idle("R8");
      send_req(32'h110, 4, 2'b00);
      expect_issue(4'b1110, 32'h110, 4, "R4", 0);
      run(4, 32'hB100, 1, 3'd0);
      wait_idle("R8");

      // R5: crossing, and cls = 0
      send_req(32'h118, 4, 2'b00);
      expect_issue(4'b1100, 32'h118, 4, "R5", 0);
      run(4, 32'hC000, 1, 3'd0);
      wait_idle("R8");
      cls = 8'd0;
      send_req(32'h700, 2, 2'b00);
      expect_issue(4'b1100, 32'h700, 2, "R5", 0);
      run(2, 32'hC100, 1, 3'd0);
      wait_idle("R8");
      cls = 8'd8;

      // R2: I/O and configuration
      send_req(32'h40, 1, 2'b01);
      expect_issue(4'b0010, 32'h40, 1, "R2", 0);
      run(1, 32'hD000, 1, 3'd0);
      wait_idle("R8");
      send_req(32'h44, 1, 2'b10);
      expect_issue(4'b1010, 32'h44, 1, "R2", 0);
      run(1, 32'hD100, 1, 3'd0);
      wait_idle("R8");

      // R9: retry
      send_req(32'h200, 2, 2'b00);
      expect_issue(4'b1110, 32'h200, 2, "R4", 0);
      run(0, 0, 1, 3'd3);
      expect_issue(4'b1110, 32'h200, 2, "R9", 0);
      run(2, 32'hE000, 1, 3'd0);
      wait_idle("R9");

      // R10: latency timer with beat in same cycle
      send_req(32'h300, 6, 2'b00);
      expect_issue(4'b1110, 32'h300, 6, "R4", 0);
      run(2, 32'hF000, 1, 3'd1);
      expect_issue(4'b1110, 32'h308, 4, "R10", 1);
      run(4, 32'hF100, 1, 3'd0);
      wait_idle("R10");

      // R10: disconnect in its own cycle
      send_req(32'h400, 4, 2'b00);
      expect_issue(4'b1110, 32'h400, 4, "R4", 0);
      run(1, 32'h1000, 0, 3'd2);
      expect_issue(4'b1110, 32'h404, 3, "R10", 0);
      run(3, 32'h1100, 1, 3'd0);
      wait_idle("R10");

      // R10, R3: continuation down to one beat
      send_req(32'h800, 2, 2'b00);
      expect_issue(4'b1110, 32'h800, 2, "R4", 0);
      run(1, 32'h2000, 1, 3'd1);
      expect_issue(4'b0110, 32'h804, 1, "R10", 0);
      run(1, 32'h2100, 1, 3'd0);
      wait_idle("R10");

      // R11: target-abort after two beats (second with the abort)
      send_req(32'h500, 5, 2'b00);
      expect_issue(4'b1110, 32'h500, 5, "R4", 0);
      push_dummy(0);
      bus_rvalid = 1; bus_rdata = 32'h3000; expq.push_back({1'b0, 32'h3000});
      @(posedge clk); #1;
      bus_rdata = 32'h3001; expq.push_back({1'b0, 32'h3001});
      push_dummy(3);
      bus_term = 1; bus_term_code = 3'd4;
      @(posedge clk); #1;
      bus_rvalid = 0; bus_term = 0;
      wait_idle("R11");

      // R11: master-abort with nothing delivered, then normal operation
      send_req(32'h600, 3, 2'b00);
      expect_issue(4'b1110, 32'h600, 3, "R4", 0);
      push_dummy(3);
      run(0, 0, 1, 3'd5);
      wait_idle("R11");
      send_req(32'h104, 1, 2'b00);
      expect_issue(4'b0110, 32'h104, 1, "R11", 0);
      run(1, 32'h4000, 1, 3'd0);
      wait_idle("R11");

      // R7: surplus beat beyond count is dropped
      send_req(32'h120, 1, 2'b00);
      expect_issue(4'b0110, 32'h120, 1, "R3", 0);
      bus_rvalid = 1; bus_rdata = 32'h5000; expq.push_back({1'b0, 32'h5000});
      @(posedge clk); #1;
      bus_rdata = 32'h5001;
      @(posedge clk); #1;
      bus_rvalid = 0; bus_term = 1; bus_term_code = 3'd0;
      @(posedge clk); #1;
      bus_term = 0;
      wait_idle("R7");

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule